// File: doc/BRIEF.md
# Programmable CRC Engine

This block computes a cyclic redundancy checksum over a stream of bytes. The checksum can be 16 or 32 bits wide. The generator polynomial, the starting value, per-byte input bit reversal, output bit reversal and a final inversion are all set through a small write port. Data bytes arrive on a separate byte port and are absorbed at one per clock. The current result is always present on a read bus.

A control bit picks what the read bus shows. It can show the finished checksum, with output reversal and inversion applied. It can also show the bare running remainder. The bare remainder is kept in a form that can be written back later as the starting value, so a long message can be checksummed in several pieces. The reset configuration produces the common 16-bit CCITT checksum that starts from all ones.

Top module: `crc_engine`

## Requirements
- R1: After reset the engine uses polynomial 0x1021, start value 0xFFFF, 16-bit width, no reversal, no inversion and finished-result readout. With no bytes sent, `rd_data` reads 0x0000FFFF. The bytes 0x31..0x39 then give 0x000029B1.
- R2: Control bit 0 selects the width (0 = 16-bit, 1 = 32-bit). In 16-bit mode, bits 31:16 of the polynomial and the start value have no effect, and `rd_data[31:16]` reads zero.
- R3: A write to address 2 loads the running remainder with `wr_data`, masked to the active width. This starts a new checksum, and the new value is readable on the next cycle.
- R4: Each byte with `din_valid` high and `wr_en` low updates the remainder in that clock edge. The update is eight shift/XOR steps that take the byte most significant bit first. The polynomial is written MSB-first without its top term. Bytes are taken in the order they arrive.
- R5: When control bit 1 is set, each input byte is bit-reversed before it enters the remainder.
- R6: When control bit 2 is set, the finished result is the remainder bit-reversed across the active width.
- R7: When control bit 3 is set, the finished result is inverted across the active width.
- R8: When control bit 4 is 1, `rd_data` shows the raw remainder, with neither reversal nor inversion. When it is 0, `rd_data` shows the finished result.
- R9: A raw remainder written back through address 2 resumes the checksum. The final value is the same as if the message had never been split.
- R10: Any register write (`wr_en` high) in the same cycle as a valid byte takes priority, and that byte is dropped. A write to address 0 or 1 leaves the remainder unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 control, 1 polynomial, 2 start value, 3 unused |
| wr_data | input | 32 | Register write data; control uses bits 4:0 |
| din_valid | input | 1 | Data byte valid |
| din | input | 8 | Data byte |
| rd_data | output | 32 | Finished checksum or raw remainder |

## Verification
The bench builds the engine with its default reset parameters: polynomial 0x1021, start value 0xFFFF and an all-zero control word. This makes the reset checksum reachable without any configuration write. Each standard checksum variant is then programmed at run time, so one build covers both widths and every combination of reversal and inversion. Those variants are checked against their published check values for the nine-byte ASCII string "123456789". The directed checks cover the remaining cases: a message split and resumed through the raw readout, bytes dropped by a colliding write, and polynomial or start values that carry upper bits in 16-bit mode.

// File: rtl/crc_pkg.sv
package crc_pkg;

    localparam int WIDE_W   = 32;
    localparam int NARROW_W = 16;
    localparam int BYTE_W   = 8;
    localparam int CTRL_W   = 5;
    localparam int ADDR_W   = 2;
    localparam int ALIGN_SH = WIDE_W - NARROW_W;

    typedef logic [WIDE_W-1:0] word_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL = 2'd0,
        REG_POLY = 2'd1,
        REG_SEED = 2'd2,
        REG_RSVD = 2'd3
    } reg_sel_e;

    // packed MSB first: bit4 raw_sel .. bit0 wide
    typedef struct packed {
        logic raw_sel;
        logic compl_out;
        logic refl_out;
        logic refl_in;
        logic wide;
    } ctrl_t;

    function automatic word_t width_mask(logic wide);
        return wide ? {WIDE_W{1'b1}} : {{ALIGN_SH{1'b0}}, {NARROW_W{1'b1}}};
    endfunction

    function automatic byte_t rev_byte(byte_t b);
        byte_t r;
        for (int i = 0; i < BYTE_W; i++) r[i] = b[BYTE_W-1-i];
        return r;
    endfunction

    function automatic word_t rev_active(word_t v, logic wide);
        word_t r_w;
        word_t r_n;
        r_w = '0;
        r_n = '0;
        for (int i = 0; i < WIDE_W; i++) r_w[i] = v[WIDE_W-1-i];
        for (int i = 0; i < NARROW_W; i++) r_n[i] = v[NARROW_W-1-i];
        return wide ? r_w : r_n;
    endfunction

endpackage

// File: rtl/crc_cfg_regs.sv
module crc_cfg_regs
    import crc_pkg::*;
#(
    parameter word_t RST_POLY = 32'h0000_1021,
    parameter ctrl_t RST_CTRL = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  word_t             wr_data,
    output ctrl_t             ctrl,
    output word_t             poly
);

    reg_sel_e sel;
    assign sel = reg_sel_e'(wr_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= RST_CTRL;
            poly <= RST_POLY;
        end else if (wr_en) begin
            case (sel)
                REG_CTRL: ctrl <= ctrl_t'(wr_data[CTRL_W-1:0]);
                REG_POLY: poly <= wr_data;
                default:  ;
            endcase
        end
    end

endmodule

// File: rtl/crc_byte_step.sv
module crc_byte_step
    import crc_pkg::*;
(
    input  logic  wide,
    input  logic  refl_in,
    input  word_t poly,
    input  word_t rem_in,
    input  byte_t din,
    output word_t rem_out
);

    // 16-bit mode runs left-aligned in the 32-bit datapath
    word_t poly_a;
    word_t rem_a;
    byte_t din_eff;
    word_t chain [0:BYTE_W];

    always_comb begin
        din_eff = refl_in ? rev_byte(din) : din;
        poly_a  = wide ? poly : (poly << ALIGN_SH);
        rem_a   = wide ? rem_in : (rem_in << ALIGN_SH);
    end

    assign chain[0] = rem_a ^ {din_eff, {(WIDE_W-BYTE_W){1'b0}}};

    generate
        for (genvar i = 0; i < BYTE_W; i++) begin : g_step
            assign chain[i+1] = chain[i][WIDE_W-1] ? ((chain[i] << 1) ^ poly_a)
                                                   : (chain[i] << 1);
        end
    endgenerate

    assign rem_out = wide ? chain[BYTE_W] : (chain[BYTE_W] >> ALIGN_SH);

endmodule

// File: rtl/crc_out_fmt.sv
module crc_out_fmt
    import crc_pkg::*;
(
    input  ctrl_t ctrl,
    input  word_t rem,
    output word_t rd_data
);

    word_t mask;
    word_t raw;
    word_t shaped;

    always_comb begin
        mask    = width_mask(ctrl.wide);
        raw     = rem & mask;
        shaped  = ctrl.refl_out ? rev_active(raw, ctrl.wide) : raw;
        shaped  = ctrl.compl_out ? (shaped ^ mask) : shaped;
        rd_data = ctrl.raw_sel ? raw : shaped;
    end

endmodule

// File: rtl/crc_engine.sv
module crc_engine
    import crc_pkg::*;
#(
    parameter word_t RST_POLY = 32'h0000_1021,
    parameter word_t RST_SEED = 32'h0000_FFFF,
    parameter ctrl_t RST_CTRL = '0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [1:0]  wr_addr,
    input  logic [31:0] wr_data,
    input  logic        din_valid,
    input  logic [7:0]  din,
    output logic [31:0] rd_data
);

    ctrl_t ctrl;
    word_t poly;
    word_t remainder_q;
    word_t rem_next;
    logic  seed_wr;
    logic  take_byte;

    crc_cfg_regs #(
        .RST_POLY (RST_POLY),
        .RST_CTRL (RST_CTRL)
    ) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .ctrl    (ctrl),
        .poly    (poly)
    );

    crc_byte_step u_step (
        .wide    (ctrl.wide),
        .refl_in (ctrl.refl_in),
        .poly    (poly),
        .rem_in  (remainder_q),
        .din     (din),
        .rem_out (rem_next)
    );

    assign seed_wr   = wr_en && (reg_sel_e'(wr_addr) == REG_SEED);
    assign take_byte = din_valid && !wr_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            remainder_q <= RST_SEED & width_mask(RST_CTRL.wide);
        end else if (seed_wr) begin
            remainder_q <= wr_data & width_mask(ctrl.wide);
        end else if (take_byte) begin
            remainder_q <= rem_next;
        end
    end

    crc_out_fmt u_fmt (
        .ctrl    (ctrl),
        .rem     (remainder_q),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/crc_engine_sva.sv
module crc_engine_sva
    import crc_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [1:0]  wr_addr,
    input logic [31:0] wr_data,
    input logic        din_valid,
    input logic [31:0] rem,
    input logic        wide,
    input logic [31:0] rd_data
);

    // R1: reset value visible on the first cycle out of reset
    a_r1_reset_value: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (rd_data == 32'h0000_FFFF));

    // R2: narrow mode keeps the upper result bits clear
    a_r2_upper_zero: assert property (@(posedge clk) disable iff (rst)
        !wide |-> (rd_data[31:16] == 16'h0000));

    // R3: a start-value write lands in the remainder next cycle
    a_r3_seed_load: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 2'd2) |=>
        (rem == ($past(wide) ? $past(wr_data) : {16'h0000, $past(wr_data[15:0])})));

    // R10: other writes win over a byte and keep the remainder
    a_r10_write_wins: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr != 2'd2) |=> $stable(rem));

    // R4: no byte and no write, remainder holds
    a_r4_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !din_valid) |=> $stable(rem));

endmodule

bind crc_engine crc_engine_sva u_sva (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .din_valid (din_valid),
    .rem       (remainder_q),
    .wide      (ctrl.wide),
    .rd_data   (rd_data)
);

// File: tb/crc_engine_test.sv
`timescale 1ns/1ps
module crc_engine_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [31:0] wr_data = '0;
    logic        din_valid = 1'b0;
    logic [7:0]  din = '0;
    logic [31:0] rd_data;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    crc_engine uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .din_valid(din_valid), .din(din), .rd_data(rd_data)
    );

    // control bits: 1 wide, 2 refl_in, 4 refl_out, 8 complement, 16 raw
    typedef struct packed {
        logic [4:0]  ctrl;
        logic [31:0] poly;
        logic [31:0] seed;
        logic [31:0] expect_v;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [0:NVEC-1] = '{
        '{5'h00, 32'h0000_1021, 32'h0000_FFFF, 32'h0000_29B1},
        '{5'h00, 32'h0000_1021, 32'h0000_0000, 32'h0000_31C3},
        '{5'h06, 32'h0000_1021, 32'h0000_0000, 32'h0000_2189},
        '{5'h06, 32'h0000_8005, 32'h0000_0000, 32'h0000_BB3D},
        '{5'h0F, 32'h04C1_1DB7, 32'hFFFF_FFFF, 32'hCBF4_3926},
        '{5'h09, 32'h04C1_1DB7, 32'hFFFF_FFFF, 32'hFC89_1918},
        '{5'h01, 32'h04C1_1DB7, 32'hFFFF_FFFF, 32'h0376_E6E7},
        '{5'h07, 32'h04C1_1DB7, 32'hFFFF_FFFF, 32'h340B_C6D9}
    };

    function automatic logic [31:0] flip32(logic [31:0] v);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) r[i] = v[31-i];
        return r;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: got %08h expected %08h", tag, act, exp);
        end
    endtask

    // all tasks start and end on a falling edge
    task automatic wr_reg(logic [1:0] a, logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic send_byte(logic [7:0] b);
        din_valid = 1'b1; din = b;
        @(negedge clk);
        din_valid = 1'b0;
    endtask

    task automatic collide(logic [1:0] a, logic [31:0] d, logic [7:0] b);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        din_valid = 1'b1; din = b;
        @(negedge clk);
        wr_en = 1'b0; din_valid = 1'b0;
    endtask

    task automatic feed(int first, int last);
        for (int i = first; i <= last; i++) send_byte(8'h30 + 8'(i));
    endtask

    task automatic setup(logic [4:0] c, logic [31:0] p, logic [31:0] s);
        wr_reg(2'd0, {27'd0, c});
        wr_reg(2'd1, p);
        wr_reg(2'd2, s);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 100000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        logic [31:0] raw_v, fin_v, a_v, b_v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state and default checksum
        check("R1 reset readout", rd_data, 32'h0000_FFFF);
        feed(1, 9);
        check("R1 default checksum", rd_data, 32'h0000_29B1);

        // R4 (with R5/R6/R7 variants): table of standard check values
        for (int v = 0; v < NVEC; v++) begin
            setup(VECS[v].ctrl, VECS[v].poly, VECS[v].seed);
            feed(1, 9);
            check($sformatf("R4 vector %0d", v), rd_data, VECS[v].expect_v);
        end

        // R3: start value loads and shows raw next cycle, masked in 16-bit mode
        wr_reg(2'd0, 32'h10);
        wr_reg(2'd2, 32'hABCD_1234);
        check("R3 seed narrow", rd_data, 32'h0000_1234);
        wr_reg(2'd0, 32'h11);
        wr_reg(2'd2, 32'hABCD_1234);
        check("R3 seed wide", rd_data, 32'hABCD_1234);

        // R2: upper bits of poly and seed ignored in 16-bit mode
        setup(5'h00, 32'hABCD_1021, 32'h5555_FFFF);
        feed(1, 9);
        check("R2 narrow ignores upper", rd_data, 32'h0000_29B1);
        // R7: inversion over 16 bits, upper reads zero
        wr_reg(2'd0, 32'h08);
        check("R7 narrow complement", rd_data, 32'h0000_D64E);
        setup(5'h09, 32'h04C1_1DB7, 32'h0F0F_0F0F);
        check("R7 wide complement", rd_data, 32'hF0F0_F0F0);

        // R6: output reversal across active width
        setup(5'h04, 32'h0000_1021, 32'h0000_0001);
        check("R6 narrow reversal", rd_data, 32'h0000_8000);
        setup(5'h05, 32'h04C1_1DB7, 32'h0000_0001);
        check("R6 wide reversal", rd_data, 32'h8000_0000);

        // R5: reversed 0x80 equals plain 0x01
        setup(5'h02, 32'h0000_1021, 32'h0000_0000);
        send_byte(8'h80);
        a_v = rd_data;
        setup(5'h00, 32'h0000_1021, 32'h0000_0000);
        send_byte(8'h01);
        b_v = rd_data;
        check("R5 input reversal", a_v, b_v);
        check("R5 nonzero result", {31'd0, a_v != 0}, 32'd1);

        // R8: raw versus finished readout
        setup(5'h1F, 32'h04C1_1DB7, 32'hFFFF_FFFF);
        feed(1, 9);
        raw_v = rd_data;
        wr_reg(2'd0, 32'h0F);
        fin_v = rd_data;
        check("R8 finished value", fin_v, 32'hCBF4_3926);
        check("R8 raw relation", ~flip32(raw_v), fin_v);

        // R9: split message resumed through raw start value
        setup(5'h1F, 32'h04C1_1DB7, 32'hFFFF_FFFF);
        feed(1, 5);
        raw_v = rd_data;
        wr_reg(2'd2, 32'h0);
        send_byte(8'hA5);
        send_byte(8'h5A);
        wr_reg(2'd2, raw_v);
        wr_reg(2'd0, 32'h0F);
        feed(6, 9);
        check("R9 resumed checksum", rd_data, 32'hCBF4_3926);

        // R10: colliding writes drop the byte
        setup(5'h00, 32'h0000_1021, 32'h0000_0000);
        collide(2'd2, 32'h0000_FFFF, 8'hAA);
        feed(1, 9);
        check("R10 seed collision", rd_data, 32'h0000_29B1);
        wr_reg(2'd2, 32'h0000_FFFF);
        feed(1, 4);
        collide(2'd1, 32'h0000_1021, 8'h55);
        collide(2'd0, 32'h0000_0000, 8'h66);
        feed(5, 9);
        check("R10 config collision", rd_data, 32'h0000_29B1);
        wr_reg(2'd2, 32'h0000_FFFF);
        collide(2'd3, 32'h0, 8'h77);
        check("R10 reserved write keeps state", rd_data, 32'h0000_FFFF);

        summary();
    end

endmodule